// File: doc/BRIEF.md
# Video Control Timing Probe

This block sits on the pixel clock in front of a test-pattern source. It takes the incoming data-enable, horizontal-sync and vertical-sync strobes and hands them on, untouched, two clocks later. While doing so it measures the geometry of the stream. It reports the number of active pixels in a line and the number of active lines in a frame. It also raises a one-clock frame-start strobe that lines up with the delayed strobes. Pattern logic downstream can scale its brightness ramps to the measured frame and restart them on that strobe.

Frame boundaries normally come from rising edges of vertical sync. Some sources drive no vertical sync at all. To handle them, the block watches the sync input for activity. If it has seen no sync edge for a set number of clocks, it switches to a second rule: it treats a data-enable-low stretch as vertical blanking once that stretch has lasted longer than twice the most recently measured line length.

Top module: `vid_timing_probe`

## Requirements
- R1: `de_o`, `hs_o` and `vs_o` equal `de_i`, `hs_i` and `vs_i` as sampled exactly two clock edges earlier.
- R2: The line length is the number of consecutive clocks with `de_i` high. At each frame boundary, `width_o` takes the length of the last complete high run before that boundary.
- R3: At each frame boundary, `height_o` takes the number of `de_i` rising edges since the previous boundary, or since reset for the first boundary.
- R4: While sync is present, a rising edge of `vs_i` is a frame boundary. `frame_start_o` is then high in the same cycle in which `vs_o` first shows 1.
- R5: While sync is absent, a frame boundary occurs on the (2L+1)-th consecutive low sample of `de_i`, where L is the latest line length. A low run of exactly 2L clocks causes no boundary. `frame_start_o` rises two clocks after that sample, in step with `de_o`. No boundary occurs before one high run has completed.
- R6: Sync counts as present from any edge of `vs_i`. It counts as absent once `VS_TIMEOUT` clocks have passed with no edge, and it is absent after reset. While sync is present, long data-enable-low runs cause no boundary.
- R7: `dims_valid_o` stays 0 until the second frame boundary after reset. It becomes 1 in the cycle in which that boundary's `frame_start_o` is high, and then stays 1.
- R8: `frame_start_o` is never high in two consecutive cycles. `width_o`, `height_o` and `dims_valid_o` change only in a cycle in which `frame_start_o` is high.
- R9: After a synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_i | input | 1 | Incoming data enable |
| hs_i | input | 1 | Incoming horizontal sync |
| vs_i | input | 1 | Incoming vertical sync |
| de_o | output | 1 | Data enable delayed by two clocks |
| hs_o | output | 1 | Horizontal sync delayed by two clocks |
| vs_o | output | 1 | Vertical sync delayed by two clocks |
| width_o | output | W_BITS | Measured active pixels per line |
| height_o | output | H_BITS | Measured active lines per frame |
| dims_valid_o | output | 1 | Dimensions come from a complete frame |
| frame_start_o | output | 1 | One-clock frame boundary strobe |

## Verification
Every result is due two clock edges after the input sample that causes it. The strobes come through the two delay stages. A frame boundary is found in the first stage and registered once, so `frame_start_o`, `width_o`, `height_o` and `dims_valid_o` land in the same cycle as the delayed strobes. The bench keeps a two-deep history of its own inputs and of its own predicted boundary events, and compares every output with the entry from two calls back at the falling clock edge. It derives each boundary event from the sync edge or from its own count of low data-enable samples against twice its own last run length. Around the switch from sync-driven to gap-driven framing, the boundary check is paused for several frames and then resumed.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

    // Latency from input pins to delayed outputs; the boundary logic
    // assumes exactly this value (one stage to detect, one to register).
    localparam int PIPE_LAT = 2;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
    } vctl_t;

    localparam vctl_t VCTL_IDLE = '0;

    function automatic logic rise(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic logic fall(input logic cur, input logic prev);
        return ~cur & prev;
    endfunction

endpackage

// File: rtl/vtd_delay.sv
module vtd_delay
    import vtd_pkg::*;
#(
    parameter int STAGES = PIPE_LAT
) (
    input  logic  clk,
    input  logic  rst,
    input  vctl_t din,
    output vctl_t tap_first,
    output vctl_t tap_last
);

    vctl_t [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= VCTL_IDLE;
        else     pipe[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= VCTL_IDLE;
            else     pipe[i] <= pipe[i-1];
        end
    end

    assign tap_first = pipe[0];
    assign tap_last  = pipe[STAGES-1];

endmodule

// File: rtl/vtd_vs_watch.sv
module vtd_vs_watch #(
    parameter int VS_TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic vs_cur,
    input  logic vs_prev,
    output logic vs_present
);

    localparam int TMO_W = $clog2(VS_TIMEOUT + 1);
    localparam logic [TMO_W-1:0] IDLE_LAST = TMO_W'(VS_TIMEOUT - 1);

    logic [TMO_W-1:0] idle_cnt;
    logic             vs_edge;

    assign vs_edge = vs_cur ^ vs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt   <= '0;
            vs_present <= 1'b0;
        end else if (vs_edge) begin
            idle_cnt   <= '0;
            vs_present <= 1'b1;
        end else if (idle_cnt == IDLE_LAST) begin
            vs_present <= 1'b0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    AST_PRESENT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        vs_edge |=> vs_present);  // R6

endmodule

// File: rtl/vtd_measure.sv
module vtd_measure
    import vtd_pkg::*;
#(
    parameter int W_BITS = 12,
    parameter int H_BITS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de_cur,
    input  logic              de_prev,
    input  logic              vs_cur,
    input  logic              vs_prev,
    input  logic              vs_present,
    output logic [W_BITS-1:0] width,
    output logic [H_BITS-1:0] height,
    output logic              dims_valid,
    output logic              frame_start
);

    localparam int GAP_W = W_BITS + 1;

    logic [W_BITS-1:0] run_cnt;
    logic [W_BITS-1:0] line_len;
    logic              len_known;
    logic [GAP_W-1:0]  gap_cnt;
    logic [H_BITS-1:0] line_cnt;
    logic              seen_one;

    logic de_up, de_down, vs_up, gap_fire, boundary;

    assign de_up    = rise(de_cur, de_prev);
    assign de_down  = fall(de_cur, de_prev);
    assign vs_up    = rise(vs_cur, vs_prev);
    assign gap_fire = ~de_cur & len_known & ~vs_present
                    & (gap_cnt == {line_len, 1'b0});
    assign boundary = (vs_up | gap_fire) & ~frame_start;

    // active run length and DE-low gap length
    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt   <= '0;
            gap_cnt   <= '0;
            line_len  <= '0;
            len_known <= 1'b0;
        end else begin
            if (de_cur) begin
                gap_cnt <= '0;
                if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
                if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
            end
            if (de_down) begin
                line_len  <= run_cnt;
                len_known <= 1'b1;
            end
        end
    end

    // line counting and frame-level capture
    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt    <= '0;
            width       <= '0;
            height      <= '0;
            seen_one    <= 1'b0;
            dims_valid  <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            frame_start <= boundary;
            if (boundary) begin
                line_cnt <= de_up ? H_BITS'(1) : '0;
                height   <= line_cnt;
                width    <= line_len;
                seen_one <= 1'b1;
                if (seen_one) dims_valid <= 1'b1;
            end else if (de_up && line_cnt != '1) begin
                line_cnt <= line_cnt + 1'b1;
            end
        end
    end

    AST_FS_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);  // R8
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        dims_valid |=> dims_valid);  // R7
    AST_DIMS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !$past(rst)) |-> ($stable(width) && $stable(height)
                                           && $stable(dims_valid)));  // R8

endmodule

// File: rtl/vid_timing_probe.sv
module vid_timing_probe
    import vtd_pkg::*;
#(
    parameter int W_BITS     = 12,
    parameter int H_BITS     = 11,
    parameter int VS_TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de_i,
    input  logic              hs_i,
    input  logic              vs_i,
    output logic              de_o,
    output logic              hs_o,
    output logic              vs_o,
    output logic [W_BITS-1:0] width_o,
    output logic [H_BITS-1:0] height_o,
    output logic              dims_valid_o,
    output logic              frame_start_o
);

    vctl_t ctl_in, ctl_s1, ctl_s2;
    logic  vs_present;

    assign ctl_in = '{de: de_i, hs: hs_i, vs: vs_i};

    vtd_delay #(.STAGES(PIPE_LAT)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .din       (ctl_in),
        .tap_first (ctl_s1),
        .tap_last  (ctl_s2)
    );

    vtd_vs_watch #(.VS_TIMEOUT(VS_TIMEOUT)) u_vs_watch (
        .clk        (clk),
        .rst        (rst),
        .vs_cur     (ctl_s1.vs),
        .vs_prev    (ctl_s2.vs),
        .vs_present (vs_present)
    );

    vtd_measure #(.W_BITS(W_BITS), .H_BITS(H_BITS)) u_measure (
        .clk         (clk),
        .rst         (rst),
        .de_cur      (ctl_s1.de),
        .de_prev     (ctl_s2.de),
        .vs_cur      (ctl_s1.vs),
        .vs_prev     (ctl_s2.vs),
        .vs_present  (vs_present),
        .width       (width_o),
        .height      (height_o),
        .dims_valid  (dims_valid_o),
        .frame_start (frame_start_o)
    );

    assign de_o = ctl_s2.de;
    assign hs_o = ctl_s2.hs;
    assign vs_o = ctl_s2.vs;

    AST_PASS_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |->
        ({de_o, hs_o, vs_o} == $past({de_i, hs_i, vs_i}, 2)));  // R1
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!frame_start_o && !dims_valid_o && width_o == '0));  // R9

endmodule

// File: tb/vid_timing_probe_bench.sv
module vid_timing_probe_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WB  = 6;
    localparam int HB  = 5;
    localparam int TMO = 100;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
    logic de_o, hs_o, vs_o, dims_valid_o, frame_start_o;
    logic [WB-1:0] width_o;
    logic [HB-1:0] height_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_timing_probe #(.W_BITS(WB), .H_BITS(HB), .VS_TIMEOUT(TMO)) u_vid_timing_probe (
        .clk(clk), .rst(rst), .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
        .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o), .width_o(width_o),
        .height_o(height_o), .dims_valid_o(dims_valid_o),
        .frame_start_o(frame_start_o)
    );

    int nvec = 0, nfail = 0, cyc = 0;
    // bench-side history and model state
    logic [2:0] h1, h2;
    logic e1, e2, last_de, last_vs, prev_fs_o, seen_line, mode_vs, fs_chk;
    int high_run, gap_run, last_len, fs_count, exp_w, exp_h;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            nfail++;
            $display("FAIL watchdog expired: actual %0d cycles, expected <= %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_clear();
        h1 = '0; h2 = '0; e1 = 0; e2 = 0; last_de = 0; last_vs = 0;
        prev_fs_o = 0; seen_line = 0; high_run = 0; gap_run = 0;
        last_len = 0; fs_count = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; de_i = 0; hs_i = 0; vs_i = 0;
        repeat (3) @(negedge clk);
        // R9: all outputs cleared by reset
        chk({de_o, hs_o, vs_o, frame_start_o, dims_valid_o} == 5'd0 && width_o == 0
            && height_o == 0, "R9", {de_o, hs_o, vs_o, frame_start_o, dims_valid_o}, 0);
        rst = 1'b0;
        model_clear();
    endtask

    // One pixel clock: check outputs due from two calls ago, then drive.
    task automatic step(input logic de, input logic hs, input logic vs);
        logic ev;
        @(negedge clk);
        // R1: delayed pass-through
        chk({de_o, hs_o, vs_o} == h2, "R1", {de_o, hs_o, vs_o}, h2);
        // R8: single-cycle strobe
        if (frame_start_o)
            chk(!prev_fs_o, "R8", prev_fs_o, 0);
        prev_fs_o = frame_start_o;
        if (fs_chk) begin
            chk(frame_start_o == e2, mode_vs ? "R4 R6" : "R5 R6", frame_start_o, e2);
            if (e2 && frame_start_o) begin
                fs_count++;
                if (fs_count == 1) begin
                    chk(!dims_valid_o, "R7", dims_valid_o, 0);
                end else begin
                    chk(dims_valid_o, "R7", dims_valid_o, 1);
                    chk(width_o == exp_w, "R2", width_o, exp_w);
                    chk(height_o == exp_h, "R3", height_o, exp_h);
                end
            end
        end
        // expected boundary event for this input sample
        ev = 0;
        if (de) begin
            high_run++;
            gap_run = 0;
        end else begin
            if (last_de) begin
                last_len = high_run;
                seen_line = 1;
                high_run = 0;
            end
            gap_run++;
        end
        if (mode_vs) ev = vs && !last_vs;
        else         ev = !de && seen_line && (gap_run == 2*last_len + 1);
        de_i = de; hs_i = hs; vs_i = vs;
        h2 = h1; h1 = {de, hs, vs};
        e2 = e1; e1 = ev;
        last_de = de; last_vs = vs;
    endtask

    // frame with VS pulse at its head
    task automatic frame_vs(input int L, input int NL, input int hb, input int vb);
        repeat (2) step(0, 0, 1);
        repeat (3) step(0, 0, 0);
        for (int n = 0; n < NL; n++) begin
            repeat (L) step(1, 0, 0);
            for (int k = 0; k < hb; k++) step(0, k == 0, 0);
        end
        repeat (vb) step(0, 0, 0);
    endtask

    // frame without VS; hb <= 2L keeps lines apart, vb makes blanking
    task automatic frame_gap(input int L, input int NL, input int hb, input int vb);
        for (int n = 0; n < NL; n++) begin
            repeat (L) step(1, 0, 0);
            for (int k = 0; k < hb; k++) step(0, k == 0, 0);
        end
        repeat (vb) step(0, 0, 0);
    endtask

    initial begin
        model_clear();
        mode_vs = 1; fs_chk = 1;
        // R4 R6: sync-driven framing over a sweep of geometries; long blanking
        // must not create extra boundaries while sync is present.
        for (int L = 1; L <= 4; L++) begin
            for (int NL = 1; NL <= 3; NL++) begin
                do_reset();
                mode_vs = 1; fs_chk = 1; exp_w = L; exp_h = NL;
                for (int f = 0; f < 3; f++) frame_vs(L, NL, 2, 4*L + 6);
                repeat (2) step(0, 0, 1);
                repeat (4) step(0, 0, 0);
            end
        end
        // R5: gap-driven framing; odd L uses hb = 2L, the longest run that
        // must not count as blanking.
        for (int L = 1; L <= 4; L++) begin
            for (int NL = 1; NL <= 3; NL++) begin
                do_reset();
                mode_vs = 0; fs_chk = 1; exp_w = L; exp_h = NL;
                for (int f = 0; f < 4; f++)
                    frame_gap(L, NL, (L % 2 == 1) ? 2*L : 1, 2*L + 3);
                repeat (4) step(0, 0, 0);
            end
        end
        // R6: sync disappears; after VS_TIMEOUT quiet clocks gap rule takes over
        do_reset();
        mode_vs = 1; fs_chk = 1; exp_w = 6; exp_h = 4;
        for (int f = 0; f < 3; f++) frame_vs(6, 4, 4, 20);
        fs_chk = 0; mode_vs = 0;
        for (int f = 0; f < 3; f++) frame_gap(6, 4, 4, 20);
        fs_count = 1; fs_chk = 1;
        for (int f = 0; f < 3; f++) frame_gap(6, 4, 4, 20);
        repeat (4) step(0, 0, 0);
        chk(fs_count >= 4, "R6", fs_count, 4);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule